// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Burst SRAM

This block is a synchronous, pipelined single-port SRAM with per-byte write enables. It is built so that a read and a write can be issued on any pair of consecutive clocks with no idle cycle on the shared data bus. The block accepts one command per rising clock edge. Write data for a command is taken two clocks after its address. Read data for a command is presented on the bus in the slot that ends two clocks after its address. Both directions therefore occupy the same bus slot, and commands of either kind can follow each other at full rate.

A load cycle starts an access at a given address. Each advance cycle that follows produces the next address of a four-beat group, in linear or interleaved order. Three synchronous chip enables qualify load cycles. A clock enable freezes every pipeline stage. An asynchronous output enable releases the bus at once. A sleep input blocks all accesses while the array keeps its contents. The bidirectional data bus is modelled as separate input, output and driver-enable signals.

Top module: `zt_sram`

## Requirements
- R1: Every command is sampled on a rising clock edge. For a read accepted at edge n, the array word appears on `dq_o` with `dq_oe_o` high during the cycle between edges n+1 and n+2. For a write accepted at edge n, `dq_i` is sampled at edge n+2.
- R2: Reads and writes may be issued on consecutive clocks in any mix. A read issued one clock after a write to the same address returns the newly written bytes merged with the old unselected bytes.
- R3: A load cycle (`adv_ld_i`=0) with all chip enables active starts a group. Each following advance cycle (`adv_ld_i`=1) accesses the next beat, keeping the direction of the load. Advance addresses keep every address bit above bit 1, and the beat counter wraps after the fourth beat.
- R4: With `burst_ilv_i`=0 at the load, beat k uses low address bits (start+k) mod 4. With `burst_ilv_i`=1, beat k uses start XOR k. The mode is taken at the load cycle only.
- R5: Byte j of the word is bits [8j+7:8j]. A write updates only the bytes whose `byte_en_i[j]` is 1, and the enables are taken with each address cycle, advance beats included.
- R6: While `clk_en_i` is 0, no command is accepted, no write data is taken, and `dq_o`/`dq_oe_o` hold their values. The pipeline resumes unchanged at the next enabled edge.
- R7: A load cycle is accepted only when `ce0_i`=1, `ce1_i`=1 and `ce2_ni`=0. Otherwise it is a no-operation and ends any group, so following advance cycles are no-operations too. Chip enables are ignored on advance cycles.
- R8: `dq_oe_o` is low in write-data slots and idle slots. It follows `oe_i` combinationally in read slots.
- R9: While `sleep_i` is 1, `dq_oe_o` is 0 and no read or write takes place, and array contents are retained. Commands on the first two rising edges after `sleep_i` falls are ignored; the third is accepted.
- R10: After reset, `dq_oe_o` is 0 and no group is active, so an advance cycle is a no-operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clk_en_i | input | 1 | Pipeline clock enable, 1 = run |
| ce0_i | input | 1 | Chip enable, active high |
| ce1_i | input | 1 | Chip enable, active high |
| ce2_ni | input | 1 | Chip enable, active low |
| adv_ld_i | input | 1 | 0 = load new address, 1 = advance group |
| we_i | input | 1 | 1 = write, 0 = read (load cycles) |
| addr_i | input | ADDR_W | Word address |
| byte_en_i | input | BYTES | Per-byte write enables |
| burst_ilv_i | input | 1 | 1 = interleaved order, 0 = linear |
| sleep_i | input | 1 | Asynchronous sleep request |
| oe_i | input | 1 | Asynchronous output enable |
| dq_i | input | BYTES*BYTE_W | Write data from the bus |
| dq_o | output | BYTES*BYTE_W | Read data to the bus |
| dq_oe_o | output | 1 | Bus driver enable |

## Verification
A wrong stage register or a broken bypass shows up as a wrong word on `dq_o` exactly two clocks after the read's address, or as a driver enable raised in a write slot, so every read is compared in that single slot. A bad sequencer state sends a beat to the wrong word. That surfaces either on the read beat itself or on the full-array read sweeps that follow each phase. A stalled cycle that leaks shows as a moved output within one clock, or as a garbage word captured from the bus. A short wake delay shows as a write accepted during the two blocked edges, visible in the next sweep.

// File: rtl/zt_sram_pkg.sv
`timescale 1ns/1ps
package zt_sram_pkg;
  localparam int unsigned ZT_BURST_LEN = 4;
  localparam int unsigned ZT_BEAT_W    = $clog2(ZT_BURST_LEN);

  typedef enum logic {
    ZT_SEQ_LINEAR = 1'b0,
    ZT_SEQ_XOR    = 1'b1
  } zt_seq_e;

  // low address bits of a beat, given the start offset and beat number
  function automatic logic [ZT_BEAT_W-1:0] zt_beat_low(
    input logic [ZT_BEAT_W-1:0] start,
    input logic [ZT_BEAT_W-1:0] beat,
    input zt_seq_e              mode
  );
    if (mode == ZT_SEQ_XOR) return start ^ beat;
    return start + beat;
  endfunction
endpackage

// File: rtl/zt_sleep_gate.sv
`timescale 1ns/1ps
module zt_sleep_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_i,
  output logic block_o
);
  logic dly1_q, dly2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly1_q <= 1'b0;
      dly2_q <= 1'b0;
    end else begin
      dly1_q <= sleep_i;
      dly2_q <= dly1_q;
    end
  end

  // blocked while asleep and for two edges after release
  assign block_o = sleep_i | dly1_q | dly2_q;
endmodule

// File: rtl/zt_burst_seq.sv
`timescale 1ns/1ps
module zt_burst_seq
  import zt_sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              block_i,
  input  logic              load_i,
  input  logic              sel_ok_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  zt_seq_e           mode_i,
  output logic              cmd_vld_o,
  output logic              cmd_we_o,
  output logic [ADDR_W-1:0] cmd_addr_o
);
  logic                 act_q, act_d;
  logic                 we_q, we_d;
  logic [ADDR_W-1:0]    base_q, base_d;
  logic [ZT_BEAT_W-1:0] beat_q, beat_d, beat_nx;
  zt_seq_e              mode_q, mode_d;

  always_comb begin
    act_d      = act_q;
    we_d       = we_q;
    base_d     = base_q;
    beat_d     = beat_q;
    mode_d     = mode_q;
    beat_nx    = beat_q + ZT_BEAT_W'(1);
    cmd_vld_o  = 1'b0;
    cmd_we_o   = we_q;
    cmd_addr_o = base_q;
    if (block_i) begin
      act_d = 1'b0;
    end else if (load_i) begin
      if (sel_ok_i) begin
        act_d      = 1'b1;
        we_d       = we_i;
        base_d     = addr_i;
        beat_d     = '0;
        mode_d     = mode_i;
        cmd_vld_o  = 1'b1;
        cmd_we_o   = we_i;
        cmd_addr_o = addr_i;
      end else begin
        act_d = 1'b0;
      end
    end else if (act_q) begin
      beat_d     = beat_nx;
      cmd_vld_o  = 1'b1;
      cmd_addr_o = {base_q[ADDR_W-1:ZT_BEAT_W],
                    zt_beat_low(base_q[ZT_BEAT_W-1:0], beat_nx, mode_q)};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      we_q   <= 1'b0;
      base_q <= '0;
      beat_q <= '0;
      mode_q <= ZT_SEQ_LINEAR;
    end else if (en_i || block_i) begin
      act_q  <= act_d;
      we_q   <= we_d;
      base_q <= base_d;
      beat_q <= beat_d;
      mode_q <= mode_d;
    end
  end
endmodule

// File: rtl/zt_array.sv
`timescale 1ns/1ps
module zt_array #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned BYTES  = 4,
  parameter int unsigned BYTE_W = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      en_i,
  input  logic                      kill_i,
  input  logic                      wr_i,
  input  logic [ADDR_W-1:0]         wr_addr_i,
  input  logic [BYTES-1:0]          wr_be_i,
  input  logic [BYTES*BYTE_W-1:0]   wr_data_i,
  input  logic                      rd_i,
  input  logic [ADDR_W-1:0]         rd_addr_i,
  output logic [BYTES*BYTE_W-1:0]   rd_data_o,
  output logic                      rd_vld_o
);
  localparam int unsigned DATA_W = BYTES * BYTE_W;
  localparam int unsigned DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] raw, merged, rd_data_q, rd_data_d;
  logic              hit, rd_vld_q, rd_vld_d;

  assign raw = mem_q[rd_addr_i];
  assign hit = wr_i && (wr_addr_i == rd_addr_i);

  // bypass the write committing on the same edge, byte by byte
  for (genvar j = 0; j < BYTES; j++) begin : g_byp
    assign merged[j*BYTE_W +: BYTE_W] = (hit && wr_be_i[j]) ?
        wr_data_i[j*BYTE_W +: BYTE_W] : raw[j*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk_i) begin
    if (en_i && wr_i && !kill_i) begin
      for (int j = 0; j < BYTES; j++) begin
        if (wr_be_i[j]) mem_q[wr_addr_i][j*BYTE_W +: BYTE_W] <= wr_data_i[j*BYTE_W +: BYTE_W];
      end
    end
  end

  always_comb begin
    rd_vld_d  = rd_vld_q;
    rd_data_d = rd_data_q;
    if (kill_i) begin
      rd_vld_d = 1'b0;
    end else if (en_i) begin
      rd_vld_d = rd_i;
      if (rd_i) rd_data_d = merged;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_vld_q <= 1'b0;
    else         rd_vld_q <= rd_vld_d;
  end

  always_ff @(posedge clk_i) begin
    rd_data_q <= rd_data_d;
  end

  assign rd_data_o = rd_data_q;
  assign rd_vld_o  = rd_vld_q;
endmodule

// File: rtl/zt_sram.sv
`timescale 1ns/1ps
module zt_sram
  import zt_sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned BYTES  = 4,
  parameter int unsigned BYTE_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clk_en_i,
  input  logic                    ce0_i,
  input  logic                    ce1_i,
  input  logic                    ce2_ni,
  input  logic                    adv_ld_i,
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [BYTES-1:0]        byte_en_i,
  input  logic                    burst_ilv_i,
  input  logic                    sleep_i,
  input  logic                    oe_i,
  input  logic [BYTES*BYTE_W-1:0] dq_i,
  output logic [BYTES*BYTE_W-1:0] dq_o,
  output logic                    dq_oe_o
);
  localparam int unsigned DATA_W = BYTES * BYTE_W;

  logic [1:0] rst_sync_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  logic              block, sel_ok, cmd_vld, cmd_we, rd_vld;
  logic [ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0] rd_data;

  assign sel_ok = ce0_i & ce1_i & ~ce2_ni;

  zt_sleep_gate u_sleep (
    .clk_i(clk_i), .rst_ni(rst_n), .sleep_i(sleep_i), .block_o(block)
  );

  zt_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_n), .en_i(clk_en_i), .block_i(block),
    .load_i(~adv_ld_i), .sel_ok_i(sel_ok), .we_i(we_i), .addr_i(addr_i),
    .mode_i(zt_seq_e'(burst_ilv_i)),
    .cmd_vld_o(cmd_vld), .cmd_we_o(cmd_we), .cmd_addr_o(cmd_addr)
  );

  // stage 1: accepted command; stage 2: waiting for its bus slot
  logic              s1_vld_q, s1_vld_d, s2_vld_q, s2_vld_d;
  logic              s1_we_q, s1_we_d, s2_we_q, s2_we_d;
  logic [ADDR_W-1:0] s1_addr_q, s1_addr_d, s2_addr_q, s2_addr_d;
  logic [BYTES-1:0]  s1_be_q, s1_be_d, s2_be_q, s2_be_d;

  always_comb begin
    s1_vld_d  = s1_vld_q;
    s1_we_d   = s1_we_q;
    s1_addr_d = s1_addr_q;
    s1_be_d   = s1_be_q;
    s2_vld_d  = s2_vld_q;
    s2_we_d   = s2_we_q;
    s2_addr_d = s2_addr_q;
    s2_be_d   = s2_be_q;
    if (block) begin
      s1_vld_d = 1'b0;
      s2_vld_d = 1'b0;
    end else if (clk_en_i) begin
      s1_vld_d  = cmd_vld;
      s1_we_d   = cmd_we;
      s1_addr_d = cmd_addr;
      s1_be_d   = byte_en_i;
      s2_vld_d  = s1_vld_q;
      s2_we_d   = s1_we_q;
      s2_addr_d = s1_addr_q;
      s2_be_d   = s1_be_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld_q <= 1'b0;
      s2_vld_q <= 1'b0;
    end else begin
      s1_vld_q <= s1_vld_d;
      s2_vld_q <= s2_vld_d;
    end
  end

  always_ff @(posedge clk_i) begin
    s1_we_q   <= s1_we_d;
    s1_addr_q <= s1_addr_d;
    s1_be_q   <= s1_be_d;
    s2_we_q   <= s2_we_d;
    s2_addr_q <= s2_addr_d;
    s2_be_q   <= s2_be_d;
  end

  zt_array #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_array (
    .clk_i(clk_i), .rst_ni(rst_n), .en_i(clk_en_i), .kill_i(block),
    .wr_i(s2_vld_q & s2_we_q), .wr_addr_i(s2_addr_q), .wr_be_i(s2_be_q),
    .wr_data_i(dq_i),
    .rd_i(s1_vld_q & ~s1_we_q), .rd_addr_i(s1_addr_q),
    .rd_data_o(rd_data), .rd_vld_o(rd_vld)
  );

  assign dq_o    = rd_data;
  assign dq_oe_o = rd_vld & oe_i & ~block;
endmodule

// File: rtl/zt_sram_chk.sv
`timescale 1ns/1ps
module zt_sram_chk
  import zt_sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clk_en_i,
  input logic              adv_ld_i,
  input logic              ce0_i,
  input logic              ce1_i,
  input logic              ce2_ni,
  input logic              sleep_i,
  input logic [DATA_W-1:0] dq_o,
  input logic              dq_oe_o,
  input logic              cmd_vld_i,
  input logic              s1_vld_i,
  input logic [ADDR_W-1:0] s1_addr_i,
  input logic              s2_vld_i,
  input logic              s2_we_i
);
  assert_stall_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_i |=> $stable(dq_o));

  assert_wr_slot_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s2_vld_i && s2_we_i) |-> !dq_oe_o);

  assert_sleep_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> !dq_oe_o);

  assert_wake_gap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(sleep_i) |-> !s1_vld_i);

  assert_burst_group_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_i && adv_ld_i && !sleep_i && s1_vld_i && cmd_vld_i) |=>
      (s1_addr_i[ADDR_W-1:ZT_BEAT_W] == $past(s1_addr_i[ADDR_W-1:ZT_BEAT_W])));

  assert_deselect_nop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_i && !adv_ld_i && !(ce0_i && ce1_i && !ce2_ni)) |=> !s1_vld_i);
endmodule

bind zt_sram zt_sram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .clk_en_i(clk_en_i), .adv_ld_i(adv_ld_i),
  .ce0_i(ce0_i), .ce1_i(ce1_i), .ce2_ni(ce2_ni), .sleep_i(sleep_i),
  .dq_o(dq_o), .dq_oe_o(dq_oe_o), .cmd_vld_i(cmd_vld),
  .s1_vld_i(s1_vld_q), .s1_addr_i(s1_addr_q),
  .s2_vld_i(s2_vld_q), .s2_we_i(s2_we_q)
);

// File: tb/zt_sram_bench.sv
`timescale 1ns/1ps
module zt_sram_bench;
  localparam int AW = 6, NB = 4, BW = 8, DW = 32, DEPTH = 64;

  logic          clk, rst_ni, clk_en_i, ce0_i, ce1_i, ce2_ni, adv_ld_i, we_i;
  logic [AW-1:0] addr_i;
  logic [NB-1:0] byte_en_i;
  logic          burst_ilv_i, sleep_i, oe_i;
  logic [DW-1:0] dq_i, dq_o;
  logic          dq_oe_o;

  zt_sram #(.ADDR_W(AW), .BYTES(NB), .BYTE_W(BW)) u_zt_sram (
    .clk_i(clk), .rst_ni(rst_ni), .clk_en_i(clk_en_i), .ce0_i(ce0_i),
    .ce1_i(ce1_i), .ce2_ni(ce2_ni), .adv_ld_i(adv_ld_i), .we_i(we_i),
    .addr_i(addr_i), .byte_en_i(byte_en_i), .burst_ilv_i(burst_ilv_i),
    .sleep_i(sleep_i), .oe_i(oe_i), .dq_i(dq_i), .dq_o(dq_o), .dq_oe_o(dq_oe_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic          vld;
    logic          we;
    logic [AW-1:0] a;
    logic [NB-1:0] be;
    logic [DW-1:0] d;
  } op_t;

  int            n_cmp, n_bad, cyc;
  string         tag;
  bit            exp_block, probe_oe;
  logic [DW-1:0] model [DEPTH];
  op_t           p1, p2;
  bit            b_act, b_we, b_ilv;
  logic [AW-1:0] b_base;
  logic [1:0]    b_beat;

  task automatic chk(input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // handle the bus slot owned by the command accepted two edges ago
  task automatic slot();
    dq_i = 32'hDEAD_0000 ^ DW'(cyc);
    if (p2.vld && p2.we) begin
      dq_i = p2.d;
      for (int j = 0; j < NB; j++)
        if (p2.be[j]) model[p2.a][j*BW +: BW] = p2.d[j*BW +: BW];
      chk("R8 driver off in write slot", DW'(dq_oe_o), 0);
    end else if (p2.vld) begin
      chk("R1 driver on in read slot", DW'(dq_oe_o), 1);
      chk("R1 read data", dq_o, model[p2.a]);
      if (probe_oe) begin
        oe_i = 1'b0; #0.5;
        chk("R8 async release", DW'(dq_oe_o), 0);
        oe_i = 1'b1; #0.5;
        chk("R8 async drive", DW'(dq_oe_o), 1);
      end
    end else begin
      chk("R8 driver off in idle slot", DW'(dq_oe_o), 0);
    end
  endtask

  task automatic step(input bit ld, input bit [2:0] ce, input bit we,
                      input logic [AW-1:0] a, input logic [NB-1:0] be, input bit ilv);
    op_t n;
    logic [1:0] lo;
    @(negedge clk);
    cyc++;
    slot();
    n = '0;
    if (exp_block) b_act = 1'b0;
    else if (ld) begin
      if (ce == 3'b110) begin
        b_act = 1'b1; b_we = we; b_base = a; b_beat = 2'd0; b_ilv = ilv;
        n.vld = 1'b1; n.we = we; n.a = a;
      end else b_act = 1'b0;
    end else if (b_act) begin
      b_beat = b_beat + 2'd1;
      lo = b_ilv ? (b_base[1:0] ^ b_beat) : (b_base[1:0] + b_beat);
      n.vld = 1'b1; n.we = b_we; n.a = {b_base[AW-1:2], lo};
    end
    n.be = be;
    n.d  = DW'(cyc) * 32'h9E37_79B1 ^ 32'h5A3C_C3A5;
    clk_en_i = 1'b1; adv_ld_i = ~ld; ce0_i = ce[2]; ce1_i = ce[1]; ce2_ni = ce[0];
    we_i = we; addr_i = a; byte_en_i = be; burst_ilv_i = ilv;
    @(posedge clk);
    p2 = p1;
    p1 = n;
  endtask

  task automatic stall();
    logic [DW-1:0] o;
    logic e;
    @(negedge clk);
    o = dq_o; e = dq_oe_o;
    clk_en_i = 1'b0; adv_ld_i = 1'b0; ce0_i = 1'b1; ce1_i = 1'b1; ce2_ni = 1'b0;
    we_i = 1'b1; addr_i = ~addr_i; byte_en_i = '1; dq_i = 32'hBAD0_BAD0;
    @(posedge clk); #1;
    chk("R6 stall holds data", dq_o, o);
    chk("R6 stall holds driver", DW'(dq_oe_o), DW'(e));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 3'b000, 1'b0, '0, '0, 1'b0);
  endtask

  task automatic read_all();
    for (int a = 0; a < DEPTH; a++) step(1'b1, 3'b110, 1'b0, AW'(a), '1, 1'b0);
    idle(2);
  endtask

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    n_cmp = 0; n_bad = 0; cyc = 0; exp_block = 0; probe_oe = 0;
    p1 = '0; p2 = '0; b_act = 0; b_we = 0; b_ilv = 0; b_base = '0; b_beat = '0;
    rst_ni = 0; clk_en_i = 1; ce0_i = 0; ce1_i = 0; ce2_ni = 1; adv_ld_i = 0;
    we_i = 0; addr_i = '0; byte_en_i = '0; burst_ilv_i = 0; sleep_i = 0; oe_i = 1;
    dq_i = '0;
    tag = "R10";
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 driver off in reset", DW'(dq_oe_o), 0);
    rst_ni = 1;
    idle(4);
    step(1'b0, 3'b110, 1'b1, 6'd5, '1, 1'b0);   // advance with no group: R10
    idle(2);

    tag = "R1";
    for (int a = 0; a < DEPTH; a++) step(1'b1, 3'b110, 1'b1, AW'(a), 4'hF, 1'b0);
    idle(2);
    read_all();

    tag = "R5";
    for (int a = 0; a < 16; a++) step(1'b1, 3'b110, 1'b1, AW'(a), 4'(a), 1'b0);
    idle(2);
    read_all();

    tag = "R2";
    for (int i = 0; i < 32; i++) begin
      logic [AW-1:0] a;
      a = AW'(i * 5);
      step(1'b1, 3'b110, 1'b1, a, 4'(i % 15 + 1), 1'b0);
      step(1'b1, 3'b110, 1'b0, a, '1, 1'b0);
      step(1'b1, 3'b110, 1'b0, a ^ 6'd1, '1, 1'b0);
      step(1'b1, 3'b110, 1'b1, a ^ 6'd1, 4'(15 - i % 15), 1'b0);
      step(1'b1, 3'b110, 1'b0, a ^ 6'd1, '1, 1'b0);
    end
    idle(2);

    tag = "R6";
    for (int i = 0; i < 16; i++) begin
      logic [AW-1:0] a;
      a = AW'(i * 7 + 3);
      step(1'b1, 3'b110, 1'b1, a, 4'(i + 1), 1'b0);
      stall();
      step(1'b1, 3'b110, 1'b0, a, '1, 1'b0);
      stall();
      stall();
      step(1'b1, 3'b110, 1'b0, a ^ 6'd8, '1, 1'b0);
    end
    idle(2);
    read_all();

    tag = "R3 R4";
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 4; s++)
        for (int d = 0; d < 2; d++) begin
          logic [AW-1:0] a;
          a = {4'(m * 8 + s * 2 + d), 2'(s)};
          step(1'b1, 3'b110, bit'(d), a, 4'hF, bit'(m));
          // five advances: wrap after four beats, mode input flipped to show it is latched
          for (int k = 0; k < 5; k++) step(1'b0, 3'b000, 1'b0, ~a, 4'(k * 3 + 1), ~bit'(m));
          idle(2);
        end
    read_all();

    tag = "R7";
    for (int c = 0; c < 8; c++) begin
      if (c != 6) begin
        step(1'b1, 3'(c), 1'b1, AW'(40 + c), 4'hF, 1'b0);
        step(1'b0, 3'b110, 1'b1, AW'(40 + c), 4'hF, 1'b0);
      end
    end
    idle(2);
    read_all();

    tag = "R8";
    probe_oe = 1;
    step(1'b1, 3'b110, 1'b0, 6'd17, '1, 1'b0);
    step(1'b1, 3'b110, 1'b1, 6'd18, 4'hF, 1'b0);
    idle(3);
    probe_oe = 0;

    tag = "R9";
    #1 sleep_i = 1'b1; exp_block = 1;
    #0.5 chk("R9 driver off asleep", DW'(dq_oe_o), 0);
    for (int i = 0; i < 4; i++) step(1'b1, 3'b110, 1'b1, AW'(i), 4'hF, 1'b0);
    #1 sleep_i = 1'b0;
    step(1'b1, 3'b110, 1'b1, 6'd20, 4'hF, 1'b0);   // first edge after release: ignored
    step(1'b1, 3'b110, 1'b1, 6'd21, 4'hF, 1'b0);   // second edge: ignored
    exp_block = 0;
    step(1'b1, 3'b110, 1'b1, 6'd22, 4'hF, 1'b0);   // third edge: accepted
    idle(2);
    read_all();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule